// File: doc/BRIEF.md
# MAC Client Stream Bridge

This block sits between one port of a multi-port Ethernet MAC and ordinary AXI4-Stream logic. On the MAC side, the client handshake carries only valid, last and ready. The payload travels separately, on a wide lane bus of 64-bit data lanes, and each lane comes with an 11-bit control word. A port owns one lane on each bus: port N uses lane 2N. The bridge lifts that lane and its byte-enables into a stream with tdata, tkeep, tvalid and tlast at the port's active width, and does the reverse for transmit.

The active width is set by `DATA_W`, which is 32 for a 10G port and 64 for a 25G port. In 32-bit mode only the low half of the lane carries data. Both directions share the single client clock of the MAC. The transmit path is purely combinational. The receive path has one register stage, so the stream outputs are clean flops.

Top module: `mac_client_bridge`

## Requirements
- R1: The TX stream tready equals the MAC-side TX ready in the same cycle.
- R2: MAC-side TX valid and last equal the stream tvalid and tlast in the same cycle. While TX valid is high and ready is low, valid, last and the lane data stay unchanged into the next cycle.
- R3: On TX, the stream tdata appears on bits [DATA_W-1:0] of lane 2*PORT_IDX of the data bus, with lane k at bits [64k+63:64k]. The rest of that lane and every other lane are driven to zero.
- R4: On TX, the control word of lane 2*PORT_IDX sits at bits [11k+10:11k] and carries tkeep in its low DATA_W/8 bits, one bit per byte with bit b enabling tdata byte b. Its other bits, and every other control word, are zero.
- R5: RX tvalid goes high one clock edge after a cycle with MAC RX valid high, and low one edge after a cycle with it low.
- R6: For an accepted RX beat, tdata equals bits [DATA_W-1:0] of lane 2*PORT_IDX and tkeep equals the low DATA_W/8 bits of that lane's control word, one cycle later. Other lanes, the upper lane bits in 32-bit mode, and the upper control bits have no effect.
- R7: RX tlast equals MAC RX last of the same beat and is low whenever tvalid is low.
- R8: In a cycle with MAC RX valid low, RX tdata and tkeep keep their previous values.
- R9: While reset (active-low) is asserted, RX tvalid, tlast, tdata and tkeep are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Client clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tx_tdata | input | DATA_W | TX stream data |
| s_tx_tkeep | input | DATA_W/8 | TX stream byte-enables |
| s_tx_tvalid | input | 1 | TX stream valid |
| s_tx_tlast | input | 1 | TX stream end of frame |
| s_tx_tready | output | 1 | TX stream ready |
| mac_tx_valid | output | 1 | MAC TX handshake valid |
| mac_tx_last | output | 1 | MAC TX handshake last |
| mac_tx_ready | input | 1 | MAC TX handshake ready |
| mac_tx_lane_data | output | 64*NUM_LANES | MAC TX lane data bus |
| mac_tx_lane_ctrl | output | 11*NUM_LANES | MAC TX lane control words |
| mac_rx_valid | input | 1 | MAC RX handshake valid |
| mac_rx_last | input | 1 | MAC RX handshake last |
| mac_rx_lane_data | input | 64*NUM_LANES | MAC RX lane data bus |
| mac_rx_lane_ctrl | input | 11*NUM_LANES | MAC RX lane control words |
| m_rx_tdata | output | DATA_W | RX stream data |
| m_rx_tkeep | output | DATA_W/8 | RX stream byte-enables |
| m_rx_tvalid | output | 1 | RX stream valid |
| m_rx_tlast | output | 1 | RX stream end of frame |

## Verification
The assertions check several properties on every cycle. They confirm that ready, valid and last pass through on transmit, and that transmit holds steady while the MAC stalls. They confirm the one-cycle valid delay on receive, that last stays low when valid is low, and that received data holds in idle cycles. Lane placement, zeroing of unused lanes and bits, byte-enable packing, and the blindness of the receive side to foreign lanes can only be shown by the bench. It sweeps data patterns across both widths and different port indices, and fills every lane with distinct values.

// File: rtl/mac_client_bridge.sv
module mac_client_bridge #(
  parameter int DATA_W    = 64,
  parameter int PORT_IDX  = 0,
  parameter int NUM_LANES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         s_tx_tdata,
  input  logic [DATA_W/8-1:0]       s_tx_tkeep,
  input  logic                      s_tx_tvalid,
  input  logic                      s_tx_tlast,
  output logic                      s_tx_tready,
  output logic                      mac_tx_valid,
  output logic                      mac_tx_last,
  input  logic                      mac_tx_ready,
  output logic [64*NUM_LANES-1:0]   mac_tx_lane_data,
  output logic [11*NUM_LANES-1:0]   mac_tx_lane_ctrl,
  input  logic                      mac_rx_valid,
  input  logic                      mac_rx_last,
  input  logic [64*NUM_LANES-1:0]   mac_rx_lane_data,
  input  logic [11*NUM_LANES-1:0]   mac_rx_lane_ctrl,
  output logic [DATA_W-1:0]         m_rx_tdata,
  output logic [DATA_W/8-1:0]       m_rx_tkeep,
  output logic                      m_rx_tvalid,
  output logic                      m_rx_tlast
);
  localparam int LANE_W = 64;
  localparam int CTRL_W = 11;
  localparam int KEEP_W = DATA_W / 8;
  localparam int SEL    = 2 * PORT_IDX;

  assign s_tx_tready  = mac_tx_ready;
  assign mac_tx_valid = s_tx_tvalid;
  assign mac_tx_last  = s_tx_tlast;

  always_comb begin
    mac_tx_lane_data = '0;
    mac_tx_lane_ctrl = '0;
    mac_tx_lane_data[SEL*LANE_W +: DATA_W] = s_tx_tdata;
    mac_tx_lane_ctrl[SEL*CTRL_W +: KEEP_W] = s_tx_tkeep;
  end

  wire [DATA_W-1:0] rx_lane_data = mac_rx_lane_data[SEL*LANE_W +: DATA_W];
  wire [KEEP_W-1:0] rx_lane_keep = mac_rx_lane_ctrl[SEL*CTRL_W +: KEEP_W];
  wire              rx_unused    = ^{mac_rx_lane_data, mac_rx_lane_ctrl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx_tvalid <= 1'b0;
      m_rx_tlast  <= 1'b0;
      m_rx_tdata  <= '0;
      m_rx_tkeep  <= '0;
    end else begin
      m_rx_tvalid <= mac_rx_valid;
      m_rx_tlast  <= mac_rx_valid & mac_rx_last;
      if (mac_rx_valid) begin
        m_rx_tdata <= rx_lane_data;
        m_rx_tkeep <= rx_lane_keep;
      end
    end
  end
endmodule

// File: rtl/mac_client_bridge_checks.sv
module mac_client_bridge_checks #(
  parameter int DATA_W    = 64,
  parameter int NUM_LANES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    s_tx_tvalid,
  input logic                    s_tx_tlast,
  input logic                    s_tx_tready,
  input logic                    mac_tx_valid,
  input logic                    mac_tx_last,
  input logic                    mac_tx_ready,
  input logic [64*NUM_LANES-1:0] mac_tx_lane_data,
  input logic                    mac_rx_valid,
  input logic [DATA_W-1:0]       m_rx_tdata,
  input logic [DATA_W/8-1:0]     m_rx_tkeep,
  input logic                    m_rx_tvalid,
  input logic                    m_rx_tlast
);
  p_tx_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_tx_tready == mac_tx_ready);
  p_tx_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_tx_valid == s_tx_tvalid) && (mac_tx_last == s_tx_tlast));
  p_tx_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_tx_valid && !mac_tx_ready) |=>
      (mac_tx_valid && $stable(mac_tx_last) && $stable(mac_tx_lane_data)));
  p_rx_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rx_valid |=> m_rx_tvalid);
  p_rx_valid_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_rx_valid |=> !m_rx_tvalid);
  p_rx_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_rx_tlast |-> m_rx_tvalid);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_rx_valid |=> ($stable(m_rx_tdata) && $stable(m_rx_tkeep)));
endmodule

bind mac_client_bridge mac_client_bridge_checks #(
  .DATA_W(DATA_W), .NUM_LANES(NUM_LANES)
) i_checks (
  .clk(clk), .rst_n(rst_n),
  .s_tx_tvalid(s_tx_tvalid), .s_tx_tlast(s_tx_tlast), .s_tx_tready(s_tx_tready),
  .mac_tx_valid(mac_tx_valid), .mac_tx_last(mac_tx_last), .mac_tx_ready(mac_tx_ready),
  .mac_tx_lane_data(mac_tx_lane_data), .mac_rx_valid(mac_rx_valid),
  .m_rx_tdata(m_rx_tdata), .m_rx_tkeep(m_rx_tkeep),
  .m_rx_tvalid(m_rx_tvalid), .m_rx_tlast(m_rx_tlast)
);

// File: tb/test_mac_client_bridge.sv
module test_mac_client_bridge;
  localparam int NL = 4;
  localparam int DW = 64 * NL;
  localparam int CW = 11 * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [63:0]   tx_d = '0;
  logic [7:0]    tx_k = '0;
  logic          tx_v = 1'b0, tx_l = 1'b0, tx_r = 1'b1;
  logic          rx_v = 1'b0, rx_l = 1'b0;
  logic [DW-1:0] rx_d = '0;
  logic [CW-1:0] rx_c = '0;

  logic          a_rdy, a_mv, a_ml, a_rv, a_rl;
  logic [DW-1:0] a_ld;
  logic [CW-1:0] a_lc;
  logic [31:0]   a_rd;
  logic [3:0]    a_rk;
  logic          b_rdy, b_mv, b_ml, b_rv, b_rl;
  logic [DW-1:0] b_ld;
  logic [CW-1:0] b_lc;
  logic [63:0]   b_rd;
  logic [7:0]    b_rk;

  mac_client_bridge #(.DATA_W(32), .PORT_IDX(1), .NUM_LANES(NL)) i_mac_client_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_tx_tdata(tx_d[31:0]), .s_tx_tkeep(tx_k[3:0]), .s_tx_tvalid(tx_v), .s_tx_tlast(tx_l),
    .s_tx_tready(a_rdy), .mac_tx_valid(a_mv), .mac_tx_last(a_ml), .mac_tx_ready(tx_r),
    .mac_tx_lane_data(a_ld), .mac_tx_lane_ctrl(a_lc),
    .mac_rx_valid(rx_v), .mac_rx_last(rx_l), .mac_rx_lane_data(rx_d), .mac_rx_lane_ctrl(rx_c),
    .m_rx_tdata(a_rd), .m_rx_tkeep(a_rk), .m_rx_tvalid(a_rv), .m_rx_tlast(a_rl));

  mac_client_bridge #(.DATA_W(64), .PORT_IDX(0), .NUM_LANES(NL)) i_mac_client_bridge_wide (
    .clk(clk), .rst_n(rst_n),
    .s_tx_tdata(tx_d), .s_tx_tkeep(tx_k), .s_tx_tvalid(tx_v), .s_tx_tlast(tx_l),
    .s_tx_tready(b_rdy), .mac_tx_valid(b_mv), .mac_tx_last(b_ml), .mac_tx_ready(tx_r),
    .mac_tx_lane_data(b_ld), .mac_tx_lane_ctrl(b_lc),
    .mac_rx_valid(rx_v), .mac_rx_last(rx_l), .mac_rx_lane_data(rx_d), .mac_rx_lane_ctrl(rx_c),
    .m_rx_tdata(b_rd), .m_rx_tkeep(b_rk), .m_rx_tvalid(b_rv), .m_rx_tlast(b_rl));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_data(input int lane, input logic [63:0] d);
    logic [DW-1:0] r = '0;
    r[lane*64 +: 64] = d;
    return r;
  endfunction

  function automatic logic [CW-1:0] exp_ctrl(input int lane, input logic [7:0] k);
    logic [CW-1:0] r = '0;
    r[lane*11 +: 8] = k;
    return r;
  endfunction

  logic [31:0] ea_d = '0;
  logic [3:0]  ea_k = '0;
  logic [63:0] eb_d = '0;
  logic [7:0]  eb_k = '0;
  logic        e_v = 1'b0, e_l = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rx tvalid in reset", {a_rv, b_rv, a_rl, b_rl}, '0);
    chk("R9 rx tdata in reset", a_rd, '0);
    chk("R9 rx tdata wide in reset", b_rd, '0);
    chk("R9 rx tkeep in reset", {a_rk, b_rk}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk("R5 rx tvalid narrow", a_rv, e_v);
      chk("R5 rx tvalid wide", b_rv, e_v);
      chk("R7 rx tlast narrow", a_rl, e_l);
      chk("R7 rx tlast wide", b_rl, e_l);
      chk("R6 R8 rx tdata narrow", a_rd, ea_d);
      chk("R6 R8 rx tkeep narrow", a_rk, ea_k);
      chk("R6 R8 rx tdata wide", b_rd, eb_d);
      chk("R6 R8 rx tkeep wide", b_rk, eb_k);

      tx_d = (64'(i) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
      tx_k = 8'(i * 37 + 5);
      tx_v = (i % 3) != 1;
      tx_l = (i % 4) == 3;
      tx_r = 1'b1;
      rx_v = (i % 3) != 0;
      rx_l = (i % 5) == 2;
      for (int j = 0; j < NL; j++) begin
        rx_d[j*64 +: 64] = tx_d ^ ({32'(j + 1), 32'(i)} * 64'hC2B2_AE3D_27D4_EB4F);
        rx_c[j*11 +: 11] = 11'(i * 13 + j * 401 + 7);
      end
      #1;
      chk("R1 tx tready narrow", a_rdy, tx_r);
      chk("R1 tx tready wide", b_rdy, tx_r);
      chk("R2 tx valid/last narrow", {a_mv, a_ml}, {tx_v, tx_l});
      chk("R2 tx valid/last wide", {b_mv, b_ml}, {tx_v, tx_l});
      chk("R3 tx lanes narrow", a_ld, exp_data(2, {32'd0, tx_d[31:0]}));
      chk("R3 tx lanes wide", b_ld, exp_data(0, tx_d));
      chk("R4 tx ctrl narrow", a_lc, exp_ctrl(2, {4'd0, tx_k[3:0]}));
      chk("R4 tx ctrl wide", b_lc, exp_ctrl(0, tx_k));

      e_v = rx_v;
      e_l = rx_v & rx_l;
      if (rx_v) begin
        ea_d = rx_d[2*64 +: 32];
        ea_k = rx_c[2*11 +: 4];
        eb_d = rx_d[63:0];
        eb_k = rx_c[7:0];
      end
    end

    @(negedge clk);
    rx_v = 1'b0;
    tx_v = 1'b1; tx_l = 1'b1; tx_r = 1'b0;
    tx_d = 64'hA5A5_0F0F_1234_5678; tx_k = 8'hF0;
    #1;
    chk("R1 tx tready stalled", {a_rdy, b_rdy}, 2'b00);
    repeat (3) @(negedge clk);
    chk("R2 tx held while stalled", b_ld, exp_data(0, 64'hA5A5_0F0F_1234_5678));
    chk("R4 tx keep held while stalled", a_lc, exp_ctrl(2, 8'h00));
    tx_r = 1'b1;
    #1;
    chk("R1 tx tready released", {a_rdy, b_rdy}, 2'b11);
    chk("R5 rx idle tvalid", {a_rv, b_rv, a_rl, b_rl}, '0);
    chk("R8 rx idle hold", b_rd, eb_d);
    @(negedge clk);
    tx_v = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule